// File: doc/BRIEF.md
# VFD Grid Scan and Blanking Timer

This block sequences the multiplexed drive of a vacuum fluorescent display with up to sixteen digit positions. An oscillator-derived tick enable advances a three-level position counter made of ticks, blanking units and digit slots. In each slot the block lights exactly one grid line. Before the grid line goes high, the block holds a programmable number of blank units so that charge does not smear from one digit into the next.

For the current slot the block presents two read addresses, one for the character memory and one for the icon memory. Each address is rotated by its own offset. The external glyph and icon lookups return a 35-bit segment pattern and a 2-bit icon pattern, and the block drives these patterns onto the segment and icon lines while the grid is lit. The display on/off flags and a blink phase generator gate the characters and the icons independently of each other.

Top module: `vfd_grid_scan`

## Requirements
- R1: While `rst` is high, and in the cycle after reset is released, `grid`, `seg` and `icon` are all zero. The position counter restarts at tick 0, unit 0, slot 0.
- R2: Each cycle in which `tick` is high advances the position by one tick. Four ticks make one blank unit and sixteen units make one slot. A cycle in which `tick` is low leaves the position and the blink phase unchanged.
- R3: With `duty_code` = k (0..7), a slot is dark during units 0 to 7-k and lit during units 8-k to 15. The lit time is therefore (8+k)/16 of the slot, and the dark part always comes at the start of the slot.
- R4: `digit_code` 0 selects 16 slots per frame and codes 1..7 select 8+code slots. After the last slot the scan wraps to slot 0.
- R5: During the lit part of slot s, `grid` is one-hot with bit s set, provided at least one of characters or icons is visible. At all other times `grid` is zero.
- R6: `chr_addr` equals (s - `chr_offset`) mod 16 and `icon_addr` equals (s - `icon_offset`) mod 16. The two offsets act independently, and the rotation covers all 16 entries whatever the digit count.
- R7: While the grid is lit and characters are visible, `seg` equals `chr_pattern`; otherwise `seg` is zero. While the grid is lit and icons are visible, `icon` equals `icon_bits`; otherwise `icon` is zero.
- R8: `blink_code` 0 keeps characters and icons steady. Code c (1..7) toggles a phase every c*BLINK_UNIT_TICKS ticks. The phase starts visible after reset and hides only the targets selected by `blink_chr` and `blink_icon`.
- R9: `chr_on` low forces `seg` to zero and `icon_on` low forces `icon` to zero. With both low, `grid`, `seg` and `icon` all stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oscillator tick enable |
| chr_on | input | 1 | Character display enable |
| icon_on | input | 1 | Icon display enable |
| duty_code | input | 3 | Lit fraction code, (8+k)/16 |
| digit_code | input | 3 | Digit count code, 0 means 16 |
| chr_offset | input | 4 | Character rotate offset |
| icon_offset | input | 4 | Icon rotate offset |
| blink_code | input | 3 | Blink interval code, 0 means steady |
| blink_chr | input | 1 | Blink applies to characters |
| blink_icon | input | 1 | Blink applies to icons |
| chr_pattern | input | 35 | Segment pattern for `chr_addr` |
| icon_bits | input | 2 | Icon pattern for `icon_addr` |
| grid | output | 16 | Grid lines, one per digit |
| seg | output | 35 | Segment lines |
| icon | output | 2 | Icon lines |
| chr_addr | output | 4 | Character memory read address |
| icon_addr | output | 4 | Icon memory read address |

## Verification
An error in the tick or unit counter shows up within one blank unit (four ticks) as a grid edge at the wrong cycle. An error in the slot counter or in its wrap point shows up on `grid` and on both read addresses within one slot. The bench compares every output in every cycle against a position derived from the number of ticks counted since reset. An offset, wrap or blink-interval mistake therefore appears in the first cycle where the rotated address or the phase diverges, which for the blink phase is at most c*BLINK_UNIT_TICKS ticks after reset.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

    localparam int DIGITS         = 16;
    localparam int DIG_W          = $clog2(DIGITS);
    localparam int TICKS_PER_UNIT = 4;
    localparam int UNITS_PER_SLOT = 16;
    localparam int TICK_W         = $clog2(TICKS_PER_UNIT);
    localparam int UNIT_W         = $clog2(UNITS_PER_SLOT);
    localparam int SEG_N          = 35;
    localparam int ICON_N         = 2;
    localparam int CODE_W         = 3;
    localparam int CNT_W          = DIG_W + 1;

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [UNIT_W-1:0] unit;
        logic [DIG_W-1:0]  slot;
    } scan_pos_t;

    // code 0 -> full width, otherwise half width plus code
    function automatic logic [CNT_W-1:0] digits_from_code(input logic [CODE_W-1:0] c);
        if (c == '0)
            return CNT_W'(DIGITS);
        return CNT_W'(DIGITS / 2) + CNT_W'(c);
    endfunction

    // number of dark units that lead each slot
    function automatic logic [UNIT_W-1:0] blank_units(input logic [CODE_W-1:0] k);
        return UNIT_W'(UNITS_PER_SLOT / 2) - UNIT_W'(k);
    endfunction

endpackage

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer
    import vfd_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [CODE_W-1:0] digit_code,
    output scan_pos_t         pos
);

    logic [CNT_W-1:0] ndig;
    logic             last_tick;
    logic             last_unit;
    logic             last_slot;

    always_comb begin
        ndig      = digits_from_code(digit_code);
        last_tick = (pos.tick == TICK_W'(TICKS_PER_UNIT - 1));
        last_unit = (pos.unit == UNIT_W'(UNITS_PER_SLOT - 1));
        last_slot = ({1'b0, pos.slot} >= (ndig - CNT_W'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (tick) begin
            if (last_tick) begin
                pos.tick <= '0;
                if (last_unit) begin
                    pos.unit <= '0;
                    pos.slot <= last_slot ? '0 : pos.slot + DIG_W'(1);
                end else begin
                    pos.unit <= pos.unit + UNIT_W'(1);
                end
            end else begin
                pos.tick <= pos.tick + TICK_W'(1);
            end
        end
    end

    p_slot_range_r4: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, pos.slot} < ndig) || $changed(digit_code) || $past(rst))
        else $error("slot beyond digit count");

    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pos))
        else $error("position moved without tick");

endmodule

// File: rtl/vfd_blink_gen.sv
module vfd_blink_gen
    import vfd_scan_pkg::*;
#(
    parameter int BLINK_UNIT_TICKS = 36000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [CODE_W-1:0] blink_code,
    output logic              shown
);

    localparam int BW = $clog2(((1 << CODE_W) - 1) * BLINK_UNIT_TICKS + 1);

    logic [BW-1:0] cnt;
    logic [BW-1:0] lim;

    always_comb lim = BW'(blink_code) * BW'(BLINK_UNIT_TICKS) - BW'(1);

    always_ff @(posedge clk) begin
        if (rst || blink_code == '0) begin
            cnt   <= '0;
            shown <= 1'b1;
        end else if (tick) begin
            if (cnt >= lim) begin
                cnt   <= '0;
                shown <= ~shown;
            end else begin
                cnt <= cnt + BW'(1);
            end
        end
    end

    p_phase_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!tick && blink_code != '0) |=> $stable(shown))
        else $error("blink phase moved without tick");

endmodule

// File: rtl/vfd_out_gate.sv
module vfd_out_gate
    import vfd_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  scan_pos_t         pos,
    input  logic [CODE_W-1:0] duty_code,
    input  logic              chr_on,
    input  logic              icon_on,
    input  logic [CODE_W-1:0] blink_code,
    input  logic              blink_chr,
    input  logic              blink_icon,
    input  logic              shown,
    input  logic [DIG_W-1:0]  chr_offset,
    input  logic [DIG_W-1:0]  icon_offset,
    input  logic [SEG_N-1:0]  chr_pattern,
    input  logic [ICON_N-1:0] icon_bits,
    output logic [DIGITS-1:0] grid,
    output logic [SEG_N-1:0]  seg,
    output logic [ICON_N-1:0] icon,
    output logic [DIG_W-1:0]  chr_addr,
    output logic [DIG_W-1:0]  icon_addr
);

    logic lit;
    logic chr_vis;
    logic icon_vis;
    logic any_vis;

    always_comb begin
        lit       = (pos.unit >= blank_units(duty_code));
        chr_vis   = chr_on  && (blink_code == '0 || !blink_chr  || shown);
        icon_vis  = icon_on && (blink_code == '0 || !blink_icon || shown);
        any_vis   = chr_vis || icon_vis;
        chr_addr  = pos.slot - chr_offset;
        icon_addr = pos.slot - icon_offset;
        seg       = (lit && chr_vis)  ? chr_pattern : '0;
        icon      = (lit && icon_vis) ? icon_bits   : '0;
    end

    for (genvar g = 0; g < DIGITS; g++) begin : g_grid
        assign grid[g] = lit && any_vis && (pos.slot == DIG_W'(g));
    end

    p_grid_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grid))
        else $error("more than one grid line lit");

    p_blank_lead_r3: assert property (@(posedge clk) disable iff (rst)
        (pos.unit == '0) |-> (grid == '0))
        else $error("grid lit in first unit of slot");

    p_dark_off_r9: assert property (@(posedge clk) disable iff (rst)
        (!chr_on && !icon_on) |-> (grid == '0 && seg == '0 && icon == '0))
        else $error("output lit with display off");

    p_steady_seg_r8: assert property (@(posedge clk) disable iff (rst)
        (blink_code == '0 && chr_on && grid != '0) |-> (seg == chr_pattern))
        else $error("steady character not driven");

endmodule

// File: rtl/vfd_grid_scan.sv
module vfd_grid_scan
    import vfd_scan_pkg::*;
#(
    parameter int BLINK_UNIT_TICKS = 36000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               chr_on,
    input  logic               icon_on,
    input  logic [2:0]         duty_code,
    input  logic [2:0]         digit_code,
    input  logic [3:0]         chr_offset,
    input  logic [3:0]         icon_offset,
    input  logic [2:0]         blink_code,
    input  logic               blink_chr,
    input  logic               blink_icon,
    input  logic [34:0]        chr_pattern,
    input  logic [1:0]         icon_bits,
    output logic [15:0]        grid,
    output logic [34:0]        seg,
    output logic [1:0]         icon,
    output logic [3:0]         chr_addr,
    output logic [3:0]         icon_addr
);

    scan_pos_t pos;
    logic      shown;

    vfd_slot_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .digit_code (digit_code),
        .pos        (pos)
    );

    vfd_blink_gen #(.BLINK_UNIT_TICKS(BLINK_UNIT_TICKS)) u_blink (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .blink_code (blink_code),
        .shown      (shown)
    );

    vfd_out_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .pos         (pos),
        .duty_code   (duty_code),
        .chr_on      (chr_on),
        .icon_on     (icon_on),
        .blink_code  (blink_code),
        .blink_chr   (blink_chr),
        .blink_icon  (blink_icon),
        .shown       (shown),
        .chr_offset  (chr_offset),
        .icon_offset (icon_offset),
        .chr_pattern (chr_pattern),
        .icon_bits   (icon_bits),
        .grid        (grid),
        .seg         (seg),
        .icon        (icon),
        .chr_addr    (chr_addr),
        .icon_addr   (icon_addr)
    );

endmodule

// File: tb/vfd_grid_scan_test.sv
`timescale 1ns/1ps
module vfd_grid_scan_test;

    localparam int BU = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        chr_on = 1'b0, icon_on = 1'b0;
    logic [2:0]  duty_code = '0, digit_code = '0, blink_code = '0;
    logic [3:0]  chr_offset = '0, icon_offset = '0;
    logic        blink_chr = 1'b0, blink_icon = 1'b0;
    logic [34:0] chr_pattern;
    logic [1:0]  icon_bits;
    logic [15:0] grid;
    logic [34:0] seg;
    logic [1:0]  icon;
    logic [3:0]  chr_addr, icon_addr;

    int n_chk = 0;
    int n_fail = 0;
    int mt = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    function automatic logic [34:0] glyph(input logic [3:0] a);
        return {~a, a, a ^ 4'h5, a + 4'd3, a, ~a + 4'd1, a ^ 4'hA, a, a[2:0]};
    endfunction

    function automatic logic [1:0] ipat(input logic [3:0] a);
        return a[1:0] ^ a[3:2] ^ 2'b01;
    endfunction

    assign chr_pattern = glyph(chr_addr);
    assign icon_bits   = ipat(icon_addr);

    always @(posedge clk) begin
        if (rst) mt <= 0;
        else if (tick) mt <= mt + 1;
    end

    vfd_grid_scan #(.BLINK_UNIT_TICKS(BU)) uut (
        .clk(clk), .rst(rst), .tick(tick), .chr_on(chr_on), .icon_on(icon_on),
        .duty_code(duty_code), .digit_code(digit_code), .chr_offset(chr_offset),
        .icon_offset(icon_offset), .blink_code(blink_code), .blink_chr(blink_chr),
        .blink_icon(blink_icon), .chr_pattern(chr_pattern), .icon_bits(icon_bits),
        .grid(grid), .seg(seg), .icon(icon), .chr_addr(chr_addr), .icon_addr(icon_addr)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at tick %0d: actual %h expected %h", req, what, mt, act, exp);
        end
    endtask

    // model of the outputs from the tick count since reset
    task automatic compare(input string req);
        int nd, unit, slot, per;
        bit lit, ph, cv, iv;
        logic [3:0] ca, ia;
        logic [15:0] eg;
        nd   = (digit_code == 0) ? 16 : 8 + int'(digit_code);
        unit = (mt / 4) % 16;
        slot = (mt / 64) % nd;
        lit  = unit >= (8 - int'(duty_code));
        per  = int'(blink_code) * BU;
        ph   = (blink_code == 0) ? 1'b1 : (((mt / per) % 2) == 0);
        cv   = chr_on  && (blink_code == 0 || !blink_chr  || ph);
        iv   = icon_on && (blink_code == 0 || !blink_icon || ph);
        ca   = 4'(slot) - chr_offset;
        ia   = 4'(slot) - icon_offset;
        eg   = (lit && (cv || iv)) ? (16'h1 << slot) : 16'h0;
        chk(req, "grid", 64'(grid), 64'(eg));
        chk(req, "chr_addr", 64'(chr_addr), 64'(ca));
        chk(req, "icon_addr", 64'(icon_addr), 64'(ia));
        chk(req, "seg", 64'(seg), (lit && cv) ? 64'(glyph(ca)) : 64'h0);
        chk(req, "icon", 64'(icon), (lit && iv) ? 64'(ipat(ia)) : 64'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst  = 1'b1;
        tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input string req, input int n, input int every);
        for (int i = 0; i < n; i++) begin
            tick = ((i % every) == 0);
            @(negedge clk);
            compare(req);
        end
        tick = 1'b0;
    endtask

    task automatic t_reset();
        chr_on = 1; icon_on = 1; duty_code = 7;
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "grid in reset", 64'(grid), 64'h0);
        chk("R1", "seg in reset", 64'(seg), 64'h0);
        chk("R1", "icon in reset", 64'(icon), 64'h0);
        chk("R1", "chr_addr in reset", 64'(chr_addr), 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "grid after reset", 64'(grid), 64'h0);
        chk("R1", "seg after reset", 64'(seg), 64'h0);
    endtask

    task automatic t_full_duty();
        chr_on = 1; icon_on = 1; duty_code = 7; digit_code = 0;
        chr_offset = 0; icon_offset = 0; blink_code = 0;
        do_reset();
        run("R5", 1100, 1);   // wraps after slot 15
    endtask

    task automatic t_low_duty_nine();
        duty_code = 0; digit_code = 1;
        do_reset();
        run("R3", 700, 1);    // nine slots, half lit, wrap checked
    endtask

    task automatic t_digits_twelve();
        duty_code = 3; digit_code = 4;
        do_reset();
        run("R4", 850, 1);
    endtask

    task automatic t_shift();
        duty_code = 7; digit_code = 0; chr_offset = 1; icon_offset = 5;
        do_reset();
        run("R6", 1100, 1);
        chr_offset = 0; icon_offset = 0;
    endtask

    task automatic t_shift_short();
        digit_code = 1; chr_offset = 4'hF; icon_offset = 3;
        do_reset();
        run("R6", 640, 1);    // rotation still over 16 entries
        chr_offset = 0; icon_offset = 0; digit_code = 0;
    endtask

    task automatic t_tick_gap();
        duty_code = 5;
        do_reset();
        run("R2", 900, 3);
    endtask

    task automatic t_blink();
        duty_code = 7; blink_code = 2; blink_chr = 1; blink_icon = 0;
        do_reset();
        run("R8", 400, 1);
        blink_chr = 0; blink_icon = 1; blink_code = 1;
        do_reset();
        run("R8", 400, 1);
        blink_code = 0; blink_icon = 0;
    endtask

    task automatic t_off();
        chr_on = 0; icon_on = 1;
        do_reset();
        run("R7", 300, 1);
        chr_on = 1; icon_on = 0;
        do_reset();
        run("R7", 300, 1);
        chr_on = 0; icon_on = 0;
        do_reset();
        run("R9", 300, 1);
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_full_duty();
        t_low_duty_nine();
        t_digits_twelve();
        t_shift();
        t_shift_short();
        t_tick_gap();
        t_blink();
        t_off();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule